// File: doc/BRIEF.md
# PC Sample Snapshot Register Bank

This block is a small register bank on an APB-style slave port. It lets an external debugger, or software on another core, look at where a running core is executing without halting that core. The live program counter (64 bits), context ID, VMID, security state, exception level, register width, power-up status, double-lock status and a profiling-prohibited flag all come in as plain inputs. The bank turns them into registers that can be read.

The central register is the low program-counter sample word. A read of it returns the live PC[31:0]. On the same access edge it latches the upper PC word, the context ID and the virtual-machine context into companion sample registers. A debugger therefore reads the low word first, then collects the matching high word and context afterwards at leisure. When the core is in debug state or profiling is prohibited, that read returns all ones and leaves the companions untouched.

An OS lock register gates the sample registers and is set at reset. A processor status register and two read-only identification registers advertise power, double-lock, which sample registers exist and the PC offset convention. Those three stay readable whatever the lock state.

Top module: `pc_sample_bank`

## Requirements
- R1: After reset the OS lock is set and all latched samples are zero, so a read of the low PC sample (byte offset 0x0A0) returns 0.
- R2: A write to byte offset 0x300 loads the OS lock from write-data bit 0. Writing 0 unlocks the sample registers and writing 1 locks them again.
- R3: A read of 0x0A0 with the OS lock clear, the power-up input high and profiling allowed returns the live PC[31:0]. In that same access the bank latches PC[63:32] (read at 0x0AC), the context ID (read at 0x0A4) and the VM context (read at 0x0A8).
- R4: Reads of 0x0A4, 0x0A8 and 0x0AC do not change anything. They return the last latched values however the live inputs move, until the next capturing read of 0x0A0.
- R5: While profiling is prohibited, a read of 0x0A0 with access permitted returns 0xFFFFFFFF and latches nothing.
- R6: While the OS lock is set or the power-up input is low, reads of 0x0A0, 0x0A4, 0x0A8 and 0x0AC return 0 and latch nothing.
- R7: The processor status register at 0x314 reports power-up in bit 0 and double lock in bit 6, with all other bits zero, and is readable at all times.
- R8: The VM context word puts non-secure state in bit 31, EL2 in bit 30 (exception-level input equal to 2), EL3 in bit 29 (exception-level input equal to 3), 64-bit width in bit 28 and the VMID in bits 7:0, with all other bits zero.
- R9: The device ID register at 0xFC8 reads the sample implementation level in bits 3:0 (default 3: PC, context ID and VM context present). The device ID1 register at 0xFC4 reads the PC offset mode in bits 3:0 (default 1: no offset). Both are readable at all times.
- R10: Writes to any offset other than 0x300 have no effect, and reads of unmapped offsets return 0 with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and sampling clock |
| rstN | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during a read access phase |
| livePc | input | 64 | Current program counter of the core |
| liveCtxId | input | 32 | Current context ID |
| liveVmid | input | 8 | Current virtual machine ID |
| liveNonSecure | input | 1 | Core in non-secure state |
| liveEl | input | 2 | Current exception level (0..3) |
| liveIs64 | input | 1 | Core executing in 64-bit state |
| corePowered | input | 1 | Core power domain up |
| dblLock | input | 1 | OS double lock set |
| profProhibit | input | 1 | Core in debug state or profiling prohibited |

## Verification
On every read access phase the assertions check several fixed rules. The identification and status words must follow their sources (R7, R9). Unmapped offsets must read zero (R10). Sample reads with the power domain down must return zero (R6). A prohibited low-PC read must return all ones or zero (R5). A permitted low-PC read must return the live PC (R3). The remaining behaviour depends on the order of accesses, and only the bench's scenarios exercise it. That covers the lock history (R1, R2) and the holding of latched companions while live inputs move (R4). It also covers the absence of a capture after prohibited, locked or powered-down reads, and writes to read-only offsets.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_PC_LO  = 12'h0A0;
  localparam logic [ADDR_W-1:0] OFF_CTX    = 12'h0A4;
  localparam logic [ADDR_W-1:0] OFF_VM     = 12'h0A8;
  localparam logic [ADDR_W-1:0] OFF_PC_HI  = 12'h0AC;
  localparam logic [ADDR_W-1:0] OFF_OSLOCK = 12'h300;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 12'h314;
  localparam logic [ADDR_W-1:0] OFF_ID1    = 12'hFC4;
  localparam logic [ADDR_W-1:0] OFF_ID     = 12'hFC8;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_PC_LO, SEL_CTX, SEL_VM, SEL_PC_HI, SEL_STATUS, SEL_ID, SEL_ID1
  } regSel_t;

  typedef struct packed {
    regSel_t sel;
    logic    rdActive;
    logic    gateOpen;
    logic    prohibited;
    logic    capture;
  } ctrlStrobe_t;
endpackage

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              wrBit0,
  input  logic              corePowered,
  input  logic              profProhibit,
  output ctrlStrobe_t       stb
);
  logic [ADDR_W-1:0] wordAddr;
  logic              accPhase;
  logic              osLock;
  regSel_t           sel;

  assign wordAddr = {paddr[ADDR_W-1:2], 2'b00};
  assign accPhase = psel && penable;

  always_comb begin
    unique case (wordAddr)
      OFF_PC_LO:  sel = SEL_PC_LO;
      OFF_CTX:    sel = SEL_CTX;
      OFF_VM:     sel = SEL_VM;
      OFF_PC_HI:  sel = SEL_PC_HI;
      OFF_STATUS: sel = SEL_STATUS;
      OFF_ID:     sel = SEL_ID;
      OFF_ID1:    sel = SEL_ID1;
      default:    sel = SEL_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          osLock <= 1'b1;
    else if (accPhase && pwrite && wordAddr == OFF_OSLOCK) osLock <= wrBit0;
  end

  always_comb begin
    stb.sel        = sel;
    stb.rdActive   = psel && !pwrite;
    stb.gateOpen   = !osLock && corePowered;
    stb.prohibited = profProhibit;
    stb.capture    = accPhase && !pwrite && sel == SEL_PC_LO
                     && !osLock && corePowered && !profProhibit;
  end
endmodule

// File: rtl/pcs_datapath.sv
module pcs_datapath
  import pcs_pkg::*;
#(
  parameter int PC_W         = 64,
  parameter int CTX_W        = 32,
  parameter int VMID_W       = 8,
  parameter int SAMPLE_LEVEL = 3,
  parameter int OFFSET_MODE  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [PC_W-1:0]   livePc,
  input  logic [CTX_W-1:0]  liveCtxId,
  input  logic [VMID_W-1:0] liveVmid,
  input  logic              liveNonSecure,
  input  logic [1:0]        liveEl,
  input  logic              liveIs64,
  input  logic              corePowered,
  input  logic              dblLock,
  output logic [DATA_W-1:0] prdata
);
  localparam int HALF = PC_W / 2;
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [HALF-1:0]   pcHiSmp;
  logic [CTX_W-1:0]  ctxSmp;
  logic [DATA_W-1:0] vmSmp;
  logic [DATA_W-1:0] vmLive;

  always_comb begin
    vmLive               = '0;
    vmLive[31]           = liveNonSecure;
    vmLive[30]           = (liveEl == 2'd2);
    vmLive[29]           = (liveEl == 2'd3);
    vmLive[28]           = liveIs64;
    vmLive[VMID_W-1:0]   = liveVmid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcHiSmp <= '0;
      ctxSmp  <= '0;
    end else if (stb.capture) begin
      pcHiSmp <= livePc[PC_W-1:HALF];
      ctxSmp  <= liveCtxId;
    end
  end

  generate
    if (SAMPLE_LEVEL >= 3) begin : g_vm
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            vmSmp <= '0;
        else if (stb.capture) vmSmp <= vmLive;
      end
    end else begin : g_novm
      assign vmSmp = '0;
    end
  endgenerate

  always_comb begin
    prdata = '0;
    if (stb.rdActive) begin
      unique case (stb.sel)
        SEL_PC_LO:  if (stb.gateOpen)
                      prdata = stb.prohibited ? ALL_ONES : livePc[DATA_W-1:0];
        SEL_CTX:    if (stb.gateOpen) prdata = ctxSmp;
        SEL_VM:     if (stb.gateOpen) prdata = vmSmp;
        SEL_PC_HI:  if (stb.gateOpen) prdata = pcHiSmp;
        SEL_STATUS: begin
                      prdata[0] = corePowered;
                      prdata[6] = dblLock;
                    end
        SEL_ID:     prdata[3:0] = 4'(SAMPLE_LEVEL);
        SEL_ID1:    prdata[3:0] = 4'(OFFSET_MODE);
        default:    prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pc_sample_bank.sv
module pc_sample_bank
  import pcs_pkg::*;
#(
  parameter int PC_W         = 64,
  parameter int CTX_W        = 32,
  parameter int VMID_W       = 8,
  parameter int SAMPLE_LEVEL = 3,
  parameter int OFFSET_MODE  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [11:0]       paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic [63:0]       livePc,
  input  logic [31:0]       liveCtxId,
  input  logic [7:0]        liveVmid,
  input  logic              liveNonSecure,
  input  logic [1:0]        liveEl,
  input  logic              liveIs64,
  input  logic              corePowered,
  input  logic              dblLock,
  input  logic              profProhibit
);
  ctrlStrobe_t stb;

  pcs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .wrBit0(pwdata[0]), .corePowered(corePowered),
    .profProhibit(profProhibit), .stb(stb)
  );

  pcs_datapath #(
    .PC_W(PC_W), .CTX_W(CTX_W), .VMID_W(VMID_W),
    .SAMPLE_LEVEL(SAMPLE_LEVEL), .OFFSET_MODE(OFFSET_MODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .livePc(livePc), .liveCtxId(liveCtxId),
    .liveVmid(liveVmid), .liveNonSecure(liveNonSecure), .liveEl(liveEl),
    .liveIs64(liveIs64), .corePowered(corePowered), .dblLock(dblLock),
    .prdata(prdata)
  );
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int SAMPLE_LEVEL = 3,
  parameter int OFFSET_MODE  = 1
) (
  input logic        clk,
  input logic        rstN,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [11:0] paddr,
  input logic [31:0] prdata,
  input logic [63:0] livePc,
  input logic        corePowered,
  input logic        dblLock,
  input logic        profProhibit,
  input logic        gateOpen
);
  logic        rdAcc;
  logic [11:0] wa;
  logic        isSample;
  logic        isMapped;

  assign rdAcc    = psel && penable && !pwrite;
  assign wa       = {paddr[11:2], 2'b00};
  assign isSample = (wa == 12'h0A0) || (wa == 12'h0A4) || (wa == 12'h0A8) || (wa == 12'h0AC);
  assign isMapped = isSample || (wa == 12'h300) || (wa == 12'h314)
                    || (wa == 12'hFC4) || (wa == 12'hFC8);

  // R3
  pc_read_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdAcc && wa == 12'h0A0 && gateOpen && !profProhibit |-> prdata == livePc[31:0]);

  // R5
  prohibited_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdAcc && wa == 12'h0A0 && corePowered && profProhibit
      |-> (prdata == 32'hFFFF_FFFF || prdata == 32'h0));

  // R6
  powered_down_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdAcc && isSample && !corePowered |-> prdata == 32'h0);

  // R7
  status_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdAcc && wa == 12'h314 |-> prdata == {25'h0, dblLock, 5'h0, corePowered});

  // R9
  id_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdAcc && wa == 12'hFC8 |-> prdata == 32'(SAMPLE_LEVEL));

  // R9
  id1_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdAcc && wa == 12'hFC4 |-> prdata == 32'(OFFSET_MODE));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdAcc && !isMapped |-> prdata == 32'h0);
endmodule

bind pc_sample_bank pcs_checker #(.SAMPLE_LEVEL(SAMPLE_LEVEL), .OFFSET_MODE(OFFSET_MODE)) u_chk (
  .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .prdata(prdata), .livePc(livePc), .corePowered(corePowered),
  .dblLock(dblLock), .profProhibit(profProhibit), .gateOpen(stb.gateOpen)
);

// File: tb/sim_pc_sample_bank.sv
`timescale 1ns/1ps
module sim_pc_sample_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [63:0] livePc = '0;
  logic [31:0] liveCtxId = '0;
  logic [7:0]  liveVmid = '0;
  logic        liveNonSecure = 1'b0;
  logic [1:0]  liveEl = '0;
  logic        liveIs64 = 1'b0;
  logic        corePowered = 1'b1;
  logic        dblLock = 1'b0;
  logic        profProhibit = 1'b0;

  int checks = 0;
  int failures = 0;

  // behavioural reference state
  bit          mLock;
  logic [31:0] mCtx, mVm, mHi;

  always #10 clk = ~clk;

  pc_sample_bank u0 (.*);

  function automatic logic [31:0] vmWord();
    return {liveNonSecure, liveEl == 2'd2, liveEl == 2'd3, liveIs64, 20'h0, liveVmid};
  endfunction

  function automatic logic [31:0] expRead(input logic [11:0] a);
    bit open = !mLock && corePowered;
    case (a)
      12'h0A0: return !open ? 32'h0 : (profProhibit ? 32'hFFFF_FFFF : livePc[31:0]);
      12'h0A4: return open ? mCtx : 32'h0;
      12'h0A8: return open ? mVm  : 32'h0;
      12'h0AC: return open ? mHi  : 32'h0;
      12'h314: return {25'h0, dblLock, 5'h0, corePowered};
      12'hFC8: return 32'd3;
      12'hFC4: return 32'd1;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    if (a == 12'h300) mLock = d[0];
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apbRead(input string req, input logic [11:0] a);
    logic [31:0] e;
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1;
    e = expRead(a);
    check(req, prdata, e);
    if (a == 12'h0A0 && !mLock && corePowered && !profProhibit) begin
      mCtx = liveCtxId; mHi = livePc[63:32]; mVm = vmWord();
    end
    @(negedge clk); psel = 0; penable = 0;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mLock = 1; mCtx = 0; mVm = 0; mHi = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    livePc = 64'h1234_5678_9ABC_DEF0; liveCtxId = 32'hCAFE_0001;
    // R1: locked after reset, samples zero
    apbRead("R1", 12'h0A0);
    apbRead("R1", 12'h0A4);
    // R7, R9: always readable
    apbRead("R7", 12'h314);
    dblLock = 1; corePowered = 1;
    apbRead("R7", 12'h314);
    dblLock = 0;
    apbRead("R9", 12'hFC8);
    apbRead("R9", 12'hFC4);
    // R2: unlock
    apbWrite(12'h300, 32'h0);
    // R3, R8: captures under several patterns
    for (int i = 0; i < 4; i++) begin
      livePc = {32'h8000_0000 + i, 32'h0000_1000 + 4*i};
      liveCtxId = 32'h100 + i; liveVmid = 8'hA0 + 8'(i);
      liveEl = 2'(i); liveNonSecure = i[0]; liveIs64 = i[1];
      apbRead("R3", 12'h0A0);
      apbRead("R3", 12'h0AC);
      apbRead("R3", 12'h0A4);
      apbRead("R8", 12'h0A8);
    end
    // R4: live inputs move, companions hold
    livePc = 64'hFFFF_0000_1111_2222; liveCtxId = 32'hDEAD_BEEF; liveVmid = 8'h55;
    liveEl = 2'd3; liveNonSecure = 1; liveIs64 = 1;
    apbRead("R4", 12'h0A4);
    apbRead("R4", 12'h0A8);
    apbRead("R4", 12'h0AC);
    // R5: prohibited
    profProhibit = 1;
    apbRead("R5", 12'h0A0);
    profProhibit = 0;
    apbRead("R5", 12'h0AC);
    apbRead("R5", 12'h0A4);
    // R6: powered down
    corePowered = 0;
    apbRead("R6", 12'h0A0);
    apbRead("R6", 12'h0A8);
    apbRead("R7", 12'h314);
    corePowered = 1;
    apbRead("R6", 12'h0AC);
    // R10: writes to read-only offsets ignored, unmapped reads zero
    apbWrite(12'h0A4, 32'h1111_1111);
    apbWrite(12'hFC8, 32'hF);
    apbRead("R10", 12'h0A4);
    apbRead("R10", 12'hFC8);
    apbRead("R10", 12'h010);
    apbRead("R10", 12'h7F0);
    // R2: relock, then locked read captures nothing
    apbWrite(12'h300, 32'h1);
    livePc = 64'h0BAD_0BAD_0BAD_0BAD;
    apbRead("R2", 12'h0A0);
    apbWrite(12'h300, 32'h0);
    apbRead("R6", 12'h0AC);
    apbRead("R3", 12'h0A0);
    apbRead("R3", 12'h0AC);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule